// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block turns a 16-bit CPU local address into an 18-bit global address. The local space is split into four 16 KB quarters. Three of the quarters always land on fixed global pages. The quarter from 0x8000 to 0xBFFF is a paging window. It lands on whichever page a 4-bit page index register currently selects. The lower 14 local bits pass through unchanged, and the page number is placed above them.

Software reaches the page register through a simple register bus and may read or write it at any time. The CPU core also has a dedicated load path, used during call and return-from-call instructions. It lets the core switch pages so that the fetch after the instruction already uses the new page. Translation is combinational from the current register value and the local address. A flag marks accesses that fall inside the paging window.

Top module: `pgwin_translator`

## Requirements
- R1: The page register holds 4 index bits in byte bits 3..0. Bits 7..4 always read as zero, and written values in those bits are discarded.
- R2: A synchronous active-high reset sets the page register to 0x0E.
- R3: The register sits at bus address 0x15. When `bus_sel` and `bus_wr` are high with that address at a clock edge, the index is written. When `bus_sel` is high and `bus_wr` is low with that address, `bus_rdata` shows the register byte after that edge. Any other bus address writes nothing and reads back 0x00.
- R4: Local addresses 0x8000..0xBFFF produce a global address equal to {page index, local[13:0]}, with `win_hit` high.
- R5: Local addresses 0x0000..0x3FFF produce {4'hC, local[13:0]}.
- R6: Local addresses 0x4000..0x7FFF produce {4'hD, local[13:0]}.
- R7: Local addresses 0xC000..0xFFFF produce {4'hF, local[13:0]}. `win_hit` is low for every address outside 0x8000..0xBFFF.
- R8: When `cpu_pg_load` is high at a clock edge, the register takes `cpu_pg_value`.
- R9: If a CPU load and a bus write to the register share a clock edge, the CPU value is kept.
- R10: `glb_addr` and `win_hit` follow `cpu_addr` with no clock delay. A register update at an edge shows in the translation right after that edge. Without a load or a write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_pg_load | input | 1 | CPU direct page load (call/return) |
| cpu_pg_value | input | 4 | Page index for the CPU load |
| cpu_addr | input | 16 | CPU local address |
| glb_addr | output | 18 | Translated global address |
| win_hit | output | 1 | Local address is inside the paging window |

## Verification
The translation outputs are combinational, so the bench checks them in the same cycle, a short delay after each new `cpu_addr`. It sweeps all 65536 local addresses for the reset page. It then checks the region boundaries for every one of the 16 page values.

The register is updated at the edge that captures a bus write or a CPU load. The bench drives these on the falling edge and checks the translation at the next falling edge. Read data is registered, so the bench samples `bus_rdata` on the falling edge that follows the capturing rising edge.

// File: rtl/mmw_pkg.sv
package mmw_pkg;
  localparam int LOCAL_W   = 16;
  localparam int IDX_W     = 4;
  localparam int OFFS_W    = LOCAL_W - 2;
  localparam int GLB_W     = IDX_W + OFFS_W;
  localparam int DATA_W    = 8;
  localparam int BADDR_W   = 8;

  typedef enum logic [1:0] {
    QTR_LOW   = 2'b00,
    QTR_MID   = 2'b01,
    QTR_WIN   = 2'b10,
    QTR_HIGH  = 2'b11
  } quarter_e;

  localparam logic [IDX_W-1:0] PG_LOW  = 4'hC;
  localparam logic [IDX_W-1:0] PG_MID  = 4'hD;
  localparam logic [IDX_W-1:0] PG_HIGH = 4'hF;
endpackage

// File: rtl/mmw_page_reg.sv
module mmw_page_reg #(
  parameter int IDX_W    = 4,
  parameter int DATA_W   = 8,
  parameter int BADDR_W  = 8,
  parameter logic [BADDR_W-1:0] REG_ADDR   = 8'h15,
  parameter logic [DATA_W-1:0]  RESET_BYTE = 8'h0E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [BADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               cpu_ld,
  input  logic [IDX_W-1:0]   cpu_val,
  output logic [IDX_W-1:0]   page_idx,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'((1 << IDX_W) - 1);

  logic [DATA_W-1:0] page_byte_q;
  logic              addr_hit;
  logic              bus_we;
  logic              bus_re;

  assign addr_hit = bus_sel && (bus_addr == REG_ADDR);
  assign bus_we   = addr_hit && bus_wr;
  assign bus_re   = addr_hit && !bus_wr;
  assign page_idx = page_byte_q[IDX_W-1:0];

  // CPU special load has priority over the register bus
  always_ff @(posedge clk) begin
    if (rst) begin
      page_byte_q <= RESET_BYTE & IDX_MASK;
    end else if (cpu_ld) begin
      page_byte_q <= {{(DATA_W-IDX_W){1'b0}}, cpu_val};
    end else if (bus_we) begin
      page_byte_q <= bus_wdata & IDX_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= page_byte_q;
    end else begin
      bus_rdata <= '0;
    end
  end

  a_r2_reset_value: assert property (@(posedge clk)
    rst |=> page_idx == RESET_BYTE[IDX_W-1:0]);

  a_r9_cpu_wins: assert property (@(posedge clk) disable iff (rst)
    cpu_ld |=> page_idx == $past(cpu_val));

  a_r3_bus_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !cpu_ld) |=> page_idx == $past(bus_wdata[IDX_W-1:0]));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && !cpu_ld) |=> $stable(page_idx));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:IDX_W] == '0);
endmodule

// File: rtl/mmw_xlate.sv
module mmw_xlate
  import mmw_pkg::*;
#(
  parameter int L_W = 16,
  parameter int P_W = 4
) (
  input  logic [P_W-1:0]       page_idx,
  input  logic [L_W-1:0]       local_addr,
  output logic [P_W+L_W-3:0]   global_addr,
  output logic                 in_window
);
  localparam int O_W = L_W - 2;

  logic [P_W-1:0] sel_page;
  quarter_e       qtr;

  assign qtr = quarter_e'(local_addr[L_W-1:L_W-2]);

  always_comb begin
    unique case (qtr)
      QTR_LOW:  sel_page = P_W'(PG_LOW);
      QTR_MID:  sel_page = P_W'(PG_MID);
      QTR_WIN:  sel_page = page_idx;
      default:  sel_page = P_W'(PG_HIGH);
    endcase
  end

  assign in_window   = (qtr == QTR_WIN);
  assign global_addr = {sel_page, local_addr[O_W-1:0]};
endmodule

// File: rtl/pgwin_translator.sv
module pgwin_translator
  import mmw_pkg::*;
#(
  parameter logic [BADDR_W-1:0] REG_ADDR   = 8'h15,
  parameter logic [DATA_W-1:0]  RESET_BYTE = 8'h0E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [BADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               cpu_pg_load,
  input  logic [IDX_W-1:0]   cpu_pg_value,
  input  logic [LOCAL_W-1:0] cpu_addr,
  output logic [GLB_W-1:0]   glb_addr,
  output logic               win_hit
);
  logic [IDX_W-1:0] page_idx;

  mmw_page_reg #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .BADDR_W(BADDR_W),
    .REG_ADDR(REG_ADDR), .RESET_BYTE(RESET_BYTE)
  ) u_page (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .cpu_ld(cpu_pg_load), .cpu_val(cpu_pg_value),
    .page_idx(page_idx), .bus_rdata(bus_rdata)
  );

  mmw_xlate #(.L_W(LOCAL_W), .P_W(IDX_W)) u_xlate (
    .page_idx(page_idx),
    .local_addr(cpu_addr),
    .global_addr(glb_addr),
    .in_window(win_hit)
  );

  a_r4_window_page: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> glb_addr[GLB_W-1:OFFS_W] == page_idx);

  a_r7_outside_fixed: assert property (@(posedge clk) disable iff (rst)
    !win_hit |-> (glb_addr[GLB_W-1:OFFS_W] == PG_LOW ||
                  glb_addr[GLB_W-1:OFFS_W] == PG_MID ||
                  glb_addr[GLB_W-1:OFFS_W] == PG_HIGH));

  a_r10_offset_pass: assert property (@(posedge clk) disable iff (rst)
    glb_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);
endmodule

// File: tb/test_pgwin_translator.sv
module test_pgwin_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cpu_pg_load = 1'b0;
  logic [3:0]  cpu_pg_value = 4'h0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [17:0] glb_addr;
  logic        win_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pgwin_translator i_pgwin_translator (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_pg_load(cpu_pg_load), .cpu_pg_value(cpu_pg_value),
    .cpu_addr(cpu_addr), .glb_addr(glb_addr), .win_hit(win_hit)
  );

  function automatic logic [17:0] exp_glb(input logic [15:0] a, input logic [3:0] pg);
    logic [3:0] p;
    case (a[15:14])
      2'b00:   p = 4'hC;
      2'b01:   p = 4'hD;
      2'b10:   p = pg;
      default: p = 4'hF;
    endcase
    return {p, a[13:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_xlate(input string req, input logic [15:0] a, input logic [3:0] pg);
    cpu_addr = a;
    #1;
    chk(req, {14'd0, glb_addr}, {14'd0, exp_glb(a, pg)});
    chk(req, {31'd0, win_hit}, {31'd0, (a[15:14] == 2'b10)});
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic cpu_load(input logic [3:0] v);
    @(negedge clk);
    cpu_pg_load = 1'b1; cpu_pg_value = v;
    @(negedge clk);
    cpu_pg_load = 1'b0;
  endtask

  logic [7:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2: reset value read back and used in the window
    bus_read(8'h15, rd);
    chk("R2 reset byte", {24'd0, rd}, 32'h0E);
    chk_xlate("R2 window at reset", 16'h8000, 4'hE);

    // R4 R5 R6 R7 R10: exhaustive sweep for the reset page
    for (int a = 0; a < 65536; a++) begin
      cpu_addr = a[15:0];
      #1;
      chk("R4-7 sweep", {14'd0, glb_addr}, {14'd0, exp_glb(a[15:0], 4'hE)});
      chk("R7 win flag", {31'd0, win_hit}, {31'd0, (a[15:14] == 2'b10)});
    end

    // R3 R4: every page via the bus, region boundaries each time
    for (int p = 0; p < 16; p++) begin
      bus_write(8'h15, {4'hA, p[3:0]});
      bus_read(8'h15, rd);
      chk("R1 upper bits zero", {24'd0, rd}, {28'd0, p[3:0]});
      chk_xlate("R5 bottom", 16'h0000, p[3:0]);
      chk_xlate("R5 top", 16'h3FFF, p[3:0]);
      chk_xlate("R6 bottom", 16'h4000, p[3:0]);
      chk_xlate("R6 top", 16'h7FFF, p[3:0]);
      chk_xlate("R4 bottom", 16'h8000, p[3:0]);
      chk_xlate("R4 mid", 16'h9A5C, p[3:0]);
      chk_xlate("R4 top", 16'hBFFF, p[3:0]);
      chk_xlate("R7 bottom", 16'hC000, p[3:0]);
      chk_xlate("R7 top", 16'hFFFF, p[3:0]);
    end

    // R3: other address neither writes nor reads
    bus_write(8'h16, 8'h03);
    chk_xlate("R3 other addr write ignored", 16'h8123, 4'hF);
    bus_write(8'h15, 8'h07);
    bus_read(8'h14, rd);
    chk("R3 other addr reads zero", {24'd0, rd}, 32'h0);

    // R8 R10: CPU load visible right after its edge
    cpu_addr = 16'hA000;
    @(negedge clk);
    cpu_pg_load = 1'b1; cpu_pg_value = 4'h3;
    #1;
    chk("R10 no change before edge", {14'd0, glb_addr}, {14'd0, exp_glb(16'hA000, 4'h7)});
    @(negedge clk);
    cpu_pg_load = 1'b0;
    #1;
    chk("R8 cpu load", {14'd0, glb_addr}, {14'd0, exp_glb(16'hA000, 4'h3)});

    // R9: simultaneous CPU load and bus write
    @(negedge clk);
    cpu_pg_load = 1'b1; cpu_pg_value = 4'h9;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h15; bus_wdata = 8'h05;
    @(negedge clk);
    cpu_pg_load = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    chk_xlate("R9 cpu wins", 16'h8001, 4'h9);
    bus_read(8'h15, rd);
    chk("R9 cpu wins readback", {24'd0, rd}, 32'h09);

    // R10: register holds over idle cycles
    repeat (5) @(negedge clk);
    chk_xlate("R10 hold", 16'hBFFE, 4'h9);

    // R2: reset again restores 0x0E
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_xlate("R2 reset restore", 16'h8000, 4'hE);
    cpu_load(4'h1);
    chk_xlate("R8 second load", 16'h8FFF, 4'h1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule